// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block maintains the four status flags of an I2C peripheral: bus busy, master role, transmit direction and address matched. It works from decoded bus events and does no bit-level work. Start, repeated Start and Stop detection, arbitration, the address phase and the software register interface are all done elsewhere. They reach this block as single-cycle pulses and read strobes. The raw SDA and SCL levels also come in, and they pass through a synchronizer before they are used.

The set and clear sources of each flag differ. The bus-busy flag follows the lines even while the peripheral is disabled. The role and direction flags drop when the peripheral is disabled. The address flag clears only after an ordered pair of reads: a read of the first status register, then a read of the second. The second status register is also presented as a packed word that holds the master, busy and direction bits.

Top module: `i2c_flag_tracker`

## Requirements
- R1: After synchronous reset, busy, msl, tra, addr_flag and every bit of sr2_word are 0.
- R2: A low level on either sda_in or scl_in sets busy on the third rising clock edge after the level is applied. Two edges go to the synchronizer and one to the flag register.
- R3: A stop_evt pulse clears busy at the next edge. This holds even when a synchronized line is low in the same cycle. If a line is still low afterwards, busy sets again one edge later.
- R4: Busy sets and clears the same way whether enable is 1 or 0.
- R5: A start_evt pulse while enable is 1 sets msl at the next edge.
- R6: msl clears at the next edge after stop_evt, arb_lost or enable at 0. Any of these wins over a start_evt in the same cycle.
- R7: An addr_done pulse while enable is 1 loads tra from addr_rw at the next edge. A value of 1 means transmitting and 0 means receiving.
- R8: tra clears at the next edge after stop_evt, rstart_evt, arb_lost or enable at 0.
- R9: An addr_done pulse while enable is 1 sets addr_flag at the next edge. A rd_sr2 strobe with no rd_sr1 strobe since the last consumed one leaves addr_flag at 1. enable at 0 clears addr_flag at the next edge.
- R10: A rd_sr1 strobe arms a marker. The marker stays armed through idle cycles and is used up by the next rd_sr2 strobe. That rd_sr2 strobe clears addr_flag at the next edge. This applies even if addr_flag was set after the rd_sr1 strobe, and it wins over an addr_done in the same cycle.
- R11: sr2_word bit 0 carries msl, bit 1 carries busy and bit 2 carries tra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA level |
| scl_in | input | 1 | Raw SCL level |
| start_evt | input | 1 | Start sent; entry to master role |
| rstart_evt | input | 1 | Repeated Start detected |
| stop_evt | input | 1 | Stop detected |
| arb_lost | input | 1 | Arbitration loss |
| addr_done | input | 1 | End of the complete address phase |
| addr_rw | input | 1 | R/W bit of the address byte, valid with addr_done |
| enable | input | 1 | Peripheral enable level |
| rd_sr1 | input | 1 | Read strobe for status register 1 |
| rd_sr2 | input | 1 | Read strobe for status register 2 |
| busy | output | 1 | Bus busy flag |
| msl | output | 1 | Master role flag |
| tra | output | 1 | Transmit direction flag |
| addr_flag | output | 1 | Address phase complete flag |
| sr2_word | output | 3 | Status register 2 bits {tra, busy, msl} |

## Verification
Every event pulse and every read strobe acts on its flag at the first clock edge after it is driven. A line level reaches busy only at the third edge. The bench drives each input just after a rising edge and samples just after the edge where the result is due. For busy, it also samples at the second edge to confirm that the flag has not yet changed. For the priority cases, the clearing and setting stimuli are driven in the same cycle and the flag is read one edge later. Each flag that must hold is read after the stimulus and before the next one.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int SR2_W    = 3;
  localparam int MSL_POS  = 0;
  localparam int BUSY_POS = 1;
  localparam int TRA_POS  = 2;
  localparam int N_LINES  = 2;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic arb;
  } bus_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '1;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '1;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/i2c_busy_flag.sv
module i2c_busy_flag #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lines,
  input  logic             stop,
  output logic             busy
);
  logic any_low;
  assign any_low = ~&lines;

  always_ff @(posedge clk) begin
    if (rst)          busy <= 1'b0;
    else if (stop)    busy <= 1'b0;
    else if (any_low) busy <= 1'b1;
  end
endmodule

// File: rtl/i2c_role_flags.sv
module i2c_role_flags
  import i2c_flag_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_evt_t evt,
  input  logic     enable,
  input  logic     addr_done,
  input  logic     addr_rw,
  output logic     msl,
  output logic     tra
);
  logic msl_clr, tra_clr;
  assign msl_clr = evt.stop | evt.arb | ~enable;
  assign tra_clr = evt.stop | evt.rstart | evt.arb | ~enable;

  always_ff @(posedge clk) begin
    if (rst)            msl <= 1'b0;
    else if (msl_clr)   msl <= 1'b0;
    else if (evt.start) msl <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            tra <= 1'b0;
    else if (tra_clr)   tra <= 1'b0;
    else if (addr_done) tra <= addr_rw;
  end
endmodule

// File: rtl/i2c_addr_flag.sv
module i2c_addr_flag (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic addr_done,
  input  logic rd_sr1,
  input  logic rd_sr2,
  output logic addr_flag
);
  logic armed;
  logic seq_clr;
  assign seq_clr = rd_sr2 & armed;

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (rd_sr1) armed <= 1'b1;
    else if (rd_sr2) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   addr_flag <= 1'b0;
    else if (seq_clr | ~enable) addr_flag <= 1'b0;
    else if (addr_done)        addr_flag <= 1'b1;
  end
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_in,
  input  logic             scl_in,
  input  logic             start_evt,
  input  logic             rstart_evt,
  input  logic             stop_evt,
  input  logic             arb_lost,
  input  logic             addr_done,
  input  logic             addr_rw,
  input  logic             enable,
  input  logic             rd_sr1,
  input  logic             rd_sr2,
  output logic             busy,
  output logic             msl,
  output logic             tra,
  output logic             addr_flag,
  output logic [SR2_W-1:0] sr2_word
);
  logic [N_LINES-1:0] lines_sync;
  bus_evt_t           evt;

  assign evt = '{start: start_evt, rstart: rstart_evt, stop: stop_evt, arb: arb_lost};

  i2c_line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din ({scl_in, sda_in}), .dout (lines_sync)
  );

  i2c_busy_flag #(.WIDTH(N_LINES)) u_busy (
    .clk (clk), .rst (rst), .lines (lines_sync), .stop (stop_evt), .busy (busy)
  );

  i2c_role_flags u_role (
    .clk (clk), .rst (rst), .evt (evt), .enable (enable),
    .addr_done (addr_done), .addr_rw (addr_rw), .msl (msl), .tra (tra)
  );

  i2c_addr_flag u_addr (
    .clk (clk), .rst (rst), .enable (enable), .addr_done (addr_done),
    .rd_sr1 (rd_sr1), .rd_sr2 (rd_sr2), .addr_flag (addr_flag)
  );

  always_comb begin
    sr2_word           = '0;
    sr2_word[MSL_POS]  = msl;
    sr2_word[BUSY_POS] = busy;
    sr2_word[TRA_POS]  = tra;
  end
endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       sda_in,
  input logic       scl_in,
  input logic       start_evt,
  input logic       rstart_evt,
  input logic       stop_evt,
  input logic       arb_lost,
  input logic       addr_done,
  input logic       addr_rw,
  input logic       enable,
  input logic       rd_sr1,
  input logic       rd_sr2,
  input logic       busy,
  input logic       msl,
  input logic       tra,
  input logic       addr_flag,
  input logic [2:0] sr2_word
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && !msl && !tra && !addr_flag));

  assert_busy_stop_R3: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !busy);

  assert_msl_set_R5: assert property (@(posedge clk) disable iff (rst)
    (start_evt && enable && !stop_evt && !arb_lost) |=> msl);

  assert_msl_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_evt || arb_lost || !enable) |=> !msl);

  assert_tra_load_R7: assert property (@(posedge clk) disable iff (rst)
    (addr_done && enable && !stop_evt && !rstart_evt && !arb_lost)
      |=> (tra == $past(addr_rw)));

  assert_tra_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_evt || rstart_evt || arb_lost || !enable) |=> !tra);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (addr_flag && enable && !rd_sr2) |=> addr_flag);

  assert_addr_disable_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !addr_flag);

  assert_word_map_R11: assert property (@(posedge clk) disable iff (rst)
    (sr2_word[0] == msl) && (sr2_word[1] == busy) && (sr2_word[2] == tra));
endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk u_chk (.*);

// File: tb/i2c_flag_tracker_bench.sv
`timescale 1ns/1ps
module i2c_flag_tracker_bench;
  logic clk = 1'b0;
  logic rst, sda_in, scl_in, start_evt, rstart_evt, stop_evt, arb_lost;
  logic addr_done, addr_rw, enable, rd_sr1, rd_sr2;
  logic busy, msl, tra, addr_flag;
  logic [2:0] sr2_word;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_flag_tracker u_i2c_flag_tracker (
    .clk (clk), .rst (rst), .sda_in (sda_in), .scl_in (scl_in),
    .start_evt (start_evt), .rstart_evt (rstart_evt), .stop_evt (stop_evt),
    .arb_lost (arb_lost), .addr_done (addr_done), .addr_rw (addr_rw),
    .enable (enable), .rd_sr1 (rd_sr1), .rd_sr2 (rd_sr2),
    .busy (busy), .msl (msl), .tra (tra), .addr_flag (addr_flag),
    .sr2_word (sr2_word)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_pulses();
    start_evt = 0; rstart_evt = 0; stop_evt = 0; arb_lost = 0;
    addr_done = 0; rd_sr1 = 0; rd_sr2 = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(3); rst = 0; tick(1);
    chk("R1 flags", {busy, msl, tra}, 3'b000);
    chk("R1 addr", {2'b0, addr_flag}, 3'b000);
    chk("R1 word", sr2_word, 3'b000);
  endtask

  task automatic t_busy_line(input bit use_scl, input bit en);
    enable = en;
    if (use_scl) scl_in = 0; else sda_in = 0;
    tick(2);
    chk("R2 busy not yet", {2'b0, busy}, 3'b000);
    tick(1);
    chk(en ? "R2 busy set" : "R4 busy set disabled", {2'b0, busy}, 3'b001);
    sda_in = 1; scl_in = 1; tick(3);
    stop_evt = 1; tick(1); stop_evt = 0;
    chk(en ? "R3 busy stop" : "R4 busy stop disabled", {2'b0, busy}, 3'b000);
    enable = 1;
  endtask

  task automatic t_busy_priority();
    scl_in = 0; tick(3);
    stop_evt = 1; tick(1); stop_evt = 0;
    chk("R3 stop wins over low line", {2'b0, busy}, 3'b000);
    scl_in = 1; tick(1);
    chk("R3 busy resets while line low", {2'b0, busy}, 3'b001);
    tick(2);
    stop_evt = 1; tick(1); stop_evt = 0;
    chk("R3 busy idle", {2'b0, busy}, 3'b000);
  endtask

  task automatic t_msl();
    start_evt = 1; tick(1); start_evt = 0;
    chk("R5 msl set", {2'b0, msl}, 3'b001);
    stop_evt = 1; tick(1); stop_evt = 0;
    chk("R6 msl stop", {2'b0, msl}, 3'b000);
    start_evt = 1; tick(1); start_evt = 0;
    arb_lost = 1; tick(1); arb_lost = 0;
    chk("R6 msl arb", {2'b0, msl}, 3'b000);
    start_evt = 1; tick(1); start_evt = 0;
    enable = 0; tick(1); enable = 1;
    chk("R6 msl disable", {2'b0, msl}, 3'b000);
    start_evt = 1; arb_lost = 1; tick(1); clear_pulses();
    chk("R6 arb wins over start", {2'b0, msl}, 3'b000);
    enable = 0; start_evt = 1; tick(1); clear_pulses(); enable = 1;
    chk("R5 start ignored disabled", {2'b0, msl}, 3'b000);
  endtask

  task automatic t_tra();
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    chk("R7 tra transmit", {2'b0, tra}, 3'b001);
    rstart_evt = 1; tick(1); clear_pulses();
    chk("R8 tra rstart", {2'b0, tra}, 3'b000);
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    addr_done = 1; addr_rw = 0; tick(1); clear_pulses();
    chk("R7 tra receive", {2'b0, tra}, 3'b000);
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    arb_lost = 1; tick(1); clear_pulses();
    chk("R8 tra arb", {2'b0, tra}, 3'b000);
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    stop_evt = 1; tick(1); clear_pulses();
    chk("R8 tra stop", {2'b0, tra}, 3'b000);
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    enable = 0; tick(1); enable = 1;
    chk("R8 tra disable", {2'b0, tra}, 3'b000);
    rd_sr1 = 1; tick(1); clear_pulses();
    rd_sr2 = 1; tick(1); clear_pulses();
  endtask

  task automatic t_addr();
    addr_done = 1; tick(1); clear_pulses();
    chk("R9 addr set", {2'b0, addr_flag}, 3'b001);
    rd_sr2 = 1; tick(1); clear_pulses();
    chk("R9 sr2 alone keeps addr", {2'b0, addr_flag}, 3'b001);
    rd_sr1 = 1; tick(1); clear_pulses();
    chk("R10 sr1 alone keeps addr", {2'b0, addr_flag}, 3'b001);
    tick(3);
    rd_sr2 = 1; tick(1); clear_pulses();
    chk("R10 ordered read clears", {2'b0, addr_flag}, 3'b000);
    rd_sr1 = 1; tick(1); clear_pulses();
    addr_done = 1; tick(1); clear_pulses();
    chk("R9 addr set after sr1", {2'b0, addr_flag}, 3'b001);
    rd_sr2 = 1; tick(1); clear_pulses();
    chk("R10 late addr still cleared", {2'b0, addr_flag}, 3'b000);
    addr_done = 1; tick(1); clear_pulses();
    rd_sr2 = 1; tick(1); clear_pulses();
    chk("R10 marker consumed", {2'b0, addr_flag}, 3'b001);
    rd_sr1 = 1; tick(1); clear_pulses();
    rd_sr2 = 1; addr_done = 1; tick(1); clear_pulses();
    chk("R10 clear wins over set", {2'b0, addr_flag}, 3'b000);
    addr_done = 1; tick(1); clear_pulses();
    enable = 0; tick(1); enable = 1;
    chk("R9 addr disable", {2'b0, addr_flag}, 3'b000);
  endtask

  task automatic t_word();
    start_evt = 1; tick(1); clear_pulses();
    chk("R11 word msl", sr2_word, 3'b001);
    addr_done = 1; addr_rw = 1; tick(1); clear_pulses();
    chk("R11 word msl tra", sr2_word, 3'b101);
    sda_in = 0; tick(3);
    chk("R11 word all", sr2_word, 3'b111);
    sda_in = 1; tick(3);
    stop_evt = 1; tick(1); clear_pulses();
    chk("R11 word cleared", sr2_word, 3'b000);
  endtask

  initial begin
    rst = 1; sda_in = 1; scl_in = 1; addr_rw = 0; enable = 1;
    clear_pulses();
    t_reset();
    t_busy_line(1'b0, 1'b1);
    t_busy_line(1'b1, 1'b1);
    t_busy_line(1'b0, 1'b0);
    t_busy_priority();
    t_msl();
    t_tra();
    t_addr();
    t_word();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule